// File: doc/BRIEF.md
# Synchronous Burst Flash Read Port

This block is a behavioural model of the device side of a synchronous burst read port on a flash array 16 bits wide. A controller drives a 21-bit word address and pulses the active-low latch input. The block captures the start address, waits a configured number of clock cycles, and then streams one word per active clock edge from sequential addresses. It continues until the chip is deselected, a new address is latched, synchronous mode is turned off, or the part is put into reset/power-down.

When the start address is not on a 4-word page boundary, the block adds wait states before the first word and flags them on a ready output. A 16-bit configuration input sets four things: the initial latency, which clock edge is active, whether ready lines up with its data or leads it by one cycle, and whether synchronous burst mode is on. The array contents come from a fixed function of the word address. This lets any word be predicted without storing the array.

Top module: `burst_flash_rd`

## Requirements
- R1: While `pwr_n` is low the block is idle, `dq_drv` is 0 and `rdy` is 1. Taking `pwr_n` low during a burst ends it at once.
- R2: A burst starts on the first active edge that sees `lat_n` low with `ce_n` low, `we_n` high and `cfg[15]` = 0, and that edge captures `addr`. A latch event with `we_n` low starts nothing and leaves the block idle.
- R3: The latency X is `cfg[13:11]`, and values below 2 are treated as 2. No word is driven in the first X-1 active edges after the capture edge. With an aligned start, the first word appears right after the X-th edge.
- R4: Once streaming, the word address goes up by one on each active edge and wraps from 0x1FFFFF to 0. The word driven for address a is `{a[7:0], a[15:8]} ^ {11'b0, a[20:16]}`.
- R5: For a start address whose bits [1:0] are not 0, there are 4 - a[1:0] wait states between the latency and the first word. No data is driven during them.
- R6: With `cfg[8]` = 0, `rdy` is low exactly during the wait-state cycles. With `cfg[8]` = 1, it goes low one cycle earlier. At all other times it is high.
- R7: `dq` is driven, and `dq_drv` is 1, only while `oe_n` is low and a valid word is being streamed. Otherwise `dq` is high impedance.
- R8: `cfg[6]` = 0 makes the rising clock edge active. `cfg[6]` = 1 makes the falling edge active.
- R9: If `lat_n` goes low and back high between two active edges, the address present at its rising edge is captured. The burst then starts at the next active edge, as in R2.
- R10: `ce_n` high at an active edge aborts the burst. A new latch event during a burst restarts it at the new address, with the full latency.
- R11: `cfg[15]` = 1 at an active edge blocks new bursts and ends a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_n | input | 1 | Reset/power-down, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, must be high for reads |
| lat_n | input | 1 | Address latch, active low |
| addr | input | 21 | Word address |
| cfg | input | 16 | Configuration: latency [13:11], edge [6], ready lead [8], mode [15] |
| dq | output | 16 | Tri-state data output |
| dq_drv | output | 1 | High while dq is driven |
| rdy | output | 1 | Low to mark wait states |

## Verification
Two events can land in the same active edge: a new latch event and a running burst that is producing a word. The bench provokes this by latching a fresh unaligned address in the middle of a stream, and also by sending a short latch pulse while the block is idle. A behavioural reference in the bench counts phases from each capture. It expects the stream to stop on that edge and the full latency and wait-state schedule to restart from the new address. Every active edge is checked against it for `rdy`, `dq_drv` and `dq`.

// File: rtl/burst_flash_rd.sv
module burst_flash_rd #(
  parameter int AW     = 21,
  parameter int DW     = 16,
  parameter int PAGE   = 4,
  parameter int LAT_LO = 2
) (
  input  logic          clk,
  input  logic          pwr_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          lat_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   cfg,
  output logic [DW-1:0] dq,
  output logic          dq_drv,
  output logic          rdy
);
  localparam int PW       = $clog2(PAGE);
  localparam int EDGE_BIT = 6;
  localparam int LEAD_BIT = 8;
  localparam int MODE_BIT = 15;
  localparam int LAT_LSB  = 11;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_WAIT, S_RUN} st_t;

  st_t           st;
  logic [2:0]    cnt;
  logic [PW:0]   wleft;
  logic [AW-1:0] waddr;
  logic [AW-1:0] l_addr;
  logic          ltog, ltog_q, lat_arm;

  wire aclk = clk ^ cfg[EDGE_BIT];

  always_ff @(posedge lat_n or negedge pwr_n)
    if (!pwr_n) begin
      ltog   <= 1'b0;
      l_addr <= '0;
    end else begin
      ltog   <= ~ltog;
      l_addr <= addr;
    end

  wire           sync_ok  = !ce_n && we_n && !cfg[MODE_BIT];
  wire           clk_lat  = !lat_n && lat_arm;
  wire           edge_lat = lat_n && lat_arm && (ltog != ltog_q);
  wire [AW-1:0]  st_addr  = clk_lat ? addr : l_addr;
  wire [2:0]     lat_cfg  = cfg[LAT_LSB +: 3];
  wire [2:0]     x_lat    = (lat_cfg < 3'(LAT_LO)) ? 3'(LAT_LO) : lat_cfg;
  wire [PW-1:0]  offs     = st_addr[PW-1:0];
  wire [PW:0]    gap      = (offs == '0) ? '0 : (PW+1)'(PAGE) - {1'b0, offs};

  always_ff @(posedge aclk or negedge pwr_n)
    if (!pwr_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wleft   <= '0;
      waddr   <= '0;
      lat_arm <= 1'b1;
      ltog_q  <= 1'b0;
    end else begin
      lat_arm <= lat_n;
      ltog_q  <= ltog;
      if (clk_lat || edge_lat) begin
        if (sync_ok) begin
          st    <= S_LAT;
          cnt   <= x_lat;
          wleft <= gap;
          waddr <= st_addr;
        end else begin
          st <= S_IDLE;
        end
      end else if (ce_n || cfg[MODE_BIT]) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_LAT:
            if (cnt == 3'd1) st <= (wleft != '0) ? S_WAIT : S_RUN;
            else             cnt <= cnt - 3'd1;
          S_WAIT:
            if (wleft == (PW+1)'(1)) st <= S_RUN;
            else                     wleft <= wleft - (PW+1)'(1);
          S_RUN:   waddr <= waddr + AW'(1);
          default: ;
        endcase
      end
    end

  wire next_wait = (st == S_LAT && cnt == 3'd1 && wleft != '0) ||
                   (st == S_WAIT && wleft > (PW+1)'(1));

  wire [DW-1:0] word = {waddr[7:0], waddr[15:8]} ^ DW'(waddr[AW-1:16]);

  assign rdy    = cfg[LEAD_BIT] ? !next_wait : (st != S_WAIT);
  assign dq_drv = !oe_n && (st == S_RUN);
  assign dq     = dq_drv ? word : 'z;
endmodule

module burst_flash_rd_chk #(
  parameter int AW = 21
) (
  input logic          aclk,
  input logic          pwr_n,
  input logic          ce_n,
  input logic          sync_off,
  input logic [1:0]    st,
  input logic [2:0]    cnt,
  input logic [AW-1:0] waddr,
  input logic          dq_drv
);
  assert_ce_abort_R10: assert property (@(posedge aclk) disable iff (!pwr_n)
    ce_n |=> st == 2'd0);

  assert_mode_off_R11: assert property (@(posedge aclk) disable iff (!pwr_n)
    sync_off |=> st == 2'd0);

  assert_latency_hold_R3: assert property (@(posedge aclk) disable iff (!pwr_n)
    (st == 2'd1 && cnt > 3'd1) |=> (st == 2'd1 || st == 2'd0));

  assert_aligned_nowait_R5: assert property (@(posedge aclk) disable iff (!pwr_n)
    (st == 2'd1 && cnt == 3'd1 && waddr[1:0] == 2'd0) |=> st != 2'd2);

  assert_addr_step_R4: assert property (@(posedge aclk) disable iff (!pwr_n)
    (st == 2'd3) |=> (st != 2'd3 || waddr == $past(waddr) + AW'(1)));

  assert_wait_quiet_R7: assert property (@(posedge aclk) disable iff (!pwr_n)
    (st == 2'd2) |-> !dq_drv);
endmodule

bind burst_flash_rd burst_flash_rd_chk #(.AW(AW)) u_chk (
  .aclk(aclk), .pwr_n(pwr_n), .ce_n(ce_n), .sync_off(cfg[15]),
  .st(st), .cnt(cnt), .waddr(waddr), .dq_drv(dq_drv)
);

// File: tb/burst_flash_rd_bench.sv
module burst_flash_rd_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        pwr_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lat_n = 1'b1;
  logic [20:0] addr = '0;
  logic [15:0] cfg = '0;
  wire  [15:0] dq;
  wire         dq_drv, rdy;

  int    n_chk = 0, n_bad = 0;
  string scen = "R1";

  burst_flash_rd u_burst_flash_rd (
    .clk(clk), .pwr_n(pwr_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .lat_n(lat_n), .addr(addr), .cfg(cfg), .dq(dq), .dq_drv(dq_drv), .rdy(rdy)
  );

  always #(PERIOD/2) clk = ~clk;

  // reference model: phase count since capture
  bit          m_busy = 0, m_arm = 1, m_tog = 0, m_togq = 0, m_ok;
  int          m_p = 0, m_x = 2, m_w = 0;
  logic [20:0] m_a = '0, m_la = '0;

  function automatic logic [15:0] fw(logic [20:0] a);
    return {a[7:0], a[15:8]} ^ {11'b0, a[20:16]};
  endfunction

  function automatic bit in_wait(int q);
    return m_busy && q >= m_x && q < m_x + m_w;
  endfunction

  task automatic m_reset();
    m_busy = 0; m_arm = 1; m_tog = 0; m_togq = 0; m_p = 0;
  endtask

  task automatic m_start(logic [20:0] a, bit ok);
    if (ok) begin
      m_busy = 1; m_p = 0; m_a = a;
      m_x = (cfg[13:11] < 3'd2) ? 2 : int'(cfg[13:11]);
      m_w = (a[1:0] == 2'd0) ? 0 : 4 - int'(a[1:0]);
    end else m_busy = 0;
  endtask

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", scen, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit erdy, edrv;
    logic [20:0] wa;
    erdy = cfg[8] ? !in_wait(m_p + 1) : !in_wait(m_p);
    edrv = m_busy && m_p >= m_x + m_w && !oe_n;
    chk("rdy (R6)", 16'(rdy), 16'(erdy));
    chk("dq_drv (R7)", 16'(dq_drv), 16'(edrv));
    if (edrv) begin
      wa = m_a + 21'(m_p - m_x - m_w);
      chk("dq (R4)", dq, fw(wa));
    end
  endtask

  always @(posedge lat_n) if (pwr_n) begin m_tog = !m_tog; m_la = addr; end
  always @(negedge pwr_n) m_reset();

  always @(clk) if ((clk ^ cfg[6]) == 1'b1) begin
    if (!pwr_n) m_reset();
    else begin
      m_ok = !ce_n && we_n && !cfg[15];
      if (!lat_n && m_arm) m_start(addr, m_ok);
      else if (lat_n && m_arm && m_tog != m_togq) m_start(m_la, m_ok);
      else if (ce_n || cfg[15]) m_busy = 0;
      else if (m_busy) m_p++;
      m_arm = lat_n; m_togq = m_tog;
    end
    #2 compare();
  end

  task automatic tick(int n);
    repeat (n) begin
      if (cfg[6]) @(negedge clk); else @(posedge clk);
      #6;
    end
  endtask

  task automatic launch(logic [20:0] a);
    addr = a; lat_n = 1'b0; tick(1); lat_n = 1'b1;
  endtask

  initial begin
    #(PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg[13:11] = 3'd3;
    tick(3);
    scen = "R1 reset";
    chk("rdy idle R1", 16'(rdy), 16'd1);
    chk("dq_drv idle R1", 16'(dq_drv), 16'd0);
    pwr_n = 1'b1; tick(1);

    scen = "R2 R3 R4 aligned start";
    ce_n = 1'b0; oe_n = 1'b0;
    launch(21'h000100); tick(12);

    scen = "R5 unaligned waits";
    cfg[13:11] = 3'd4;
    launch(21'h000101); tick(12);
    launch(21'h000103); tick(10);

    scen = "R6 early ready";
    cfg[8] = 1'b1; launch(21'h000102); tick(10); cfg[8] = 1'b0;

    scen = "R7 output enable";
    launch(21'h000040); tick(7); oe_n = 1'b1; tick(3); oe_n = 1'b0; tick(3);

    scen = "R4 address wrap";
    cfg[13:11] = 3'd2; launch(21'h1FFFFC); tick(10);

    scen = "R10 abort and restart";
    ce_n = 1'b1; tick(2); ce_n = 1'b0; tick(2);
    launch(21'h000200); tick(6);
    launch(21'h000305); tick(10);

    scen = "R2 write enable low";
    we_n = 1'b0; launch(21'h000010); tick(8); we_n = 1'b1;

    scen = "R11 mode select";
    cfg[15] = 1'b1; launch(21'h000020); tick(6);
    cfg[15] = 1'b0; launch(21'h000020); tick(6);
    cfg[15] = 1'b1; tick(2); cfg[15] = 1'b0; tick(2);

    scen = "R9 latch rising edge";
    addr = 21'h000077; lat_n = 1'b0; #2; lat_n = 1'b1; addr = 21'h000000;
    tick(10);

    scen = "R3 latency clamp";
    cfg[13:11] = 3'd0; launch(21'h000080); tick(8);
    cfg[13:11] = 3'd7; launch(21'h000084); tick(12);

    scen = "R1 power-down mid burst";
    launch(21'h000090); tick(9); pwr_n = 1'b0; tick(2); pwr_n = 1'b1; tick(2);

    scen = "R8 falling edge";
    pwr_n = 1'b0; cfg[6] = 1'b1; tick(2); pwr_n = 1'b1; tick(1);
    cfg[13:11] = 3'd3; launch(21'h000011); tick(12);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule